// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block combines five reset causes into one system reset. The causes are an active-low external reset pin, a detector that sees the system clock stop, a comparator output, a watchdog expiry pulse, and a software-forced supply-monitor reset. A free-running reference clock runs the sequencer. Because of this, the block can still time a reset, and enter one, when the system clock has stopped. Every cause holds the reset for a minimum number of reference cycles. The release is then synchronized to the system clock. The assertion is asynchronous.

A single 8-bit status word has two roles. A read returns a one-hot record of the cause that started the most recent reset. A write to the same bit positions enables the clock-loss and comparator sources, sets the watchdog enable, or forces a supply-monitor reset. The pin is an input only, and no internal cause drives it. The block also gives the watchdog its enable and a tick at one twelfth of the system clock rate.

Top module: `rst_hub`

## Requirements
- R1: When `pin_n` is held low, `sys_rst` asserts. When the reset that followed is released, `rd_data` reads 8'h01 (bit 0).
- R2: With bit 2 written as 1, a system clock that stays high or stays low for more than `MISS_CYC` reference cycles asserts `sys_rst`, and the status then reads 8'h04. With bit 2 written as 0, a stopped clock causes no reset.
- R3: With bit 5 written as 1, a low `cmp_out` asserts `sys_rst`, and the status then reads 8'h20. With bit 5 as 0, `cmp_out` is ignored.
- R4: A `wdt_expire` pulse while `wdt_en` is 1 asserts `sys_rst`, and the status then reads 8'h08. While `wdt_en` is 0 the pulse has no effect.
- R5: A write with bit 1 set while `sup_ok` is 1 forces a reset, and the status then reads 8'h02. While `sup_ok` is 0 the same write forces nothing.
- R6: The status holds at most one set bit, and bits 4, 6 and 7 always read 0. The bit is latched only when a reset starts. Its priority order is pin (bit 0), supply (bit 1), clock loss (bit 2), watchdog (bit 3), comparator (bit 5). The status does not change while `sys_rst` is low.
- R7: After the last active cause clears, `sys_rst` stays high for at least `HOLD` reference cycles. It then falls on a rising edge of `clk`.
- R8: While `por_n` is low, `sys_rst` is high. After `por_n` rises, the status reads 0, the clock-loss and comparator sources are disabled, and `wdt_en` is 1.
- R9: Every reset sets `wdt_en` to 1. Outside reset, a write loads `wdt_en` from bit 3.
- R10: While `wdt_en` is 1 and the block is out of reset, `wdt_tick` is a one-cycle pulse every `TICK_DIV` (12) `clk` cycles. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it is both monitored and used |
| ref_clk | input | 1 | Free-running reference clock for the sequencer |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| pin_n | input | 1 | External reset pin, active low |
| cmp_out | input | 1 | Comparator result; low requests a reset |
| wdt_expire | input | 1 | Watchdog expiry pulse (clk domain) |
| sup_ok | input | 1 | Supply monitor is enabled |
| wr_en | input | 1 | Status word write strobe |
| wr_data | input | 8 | Status word write data |
| sys_rst | output | 1 | System reset, active high |
| rd_data | output | 8 | One-hot record of the last reset cause |
| wdt_en | output | 1 | Watchdog enable |
| wdt_tick | output | 1 | Watchdog count tick, clk/12 |

## Verification
The hardest case to reach is a clock-loss reset, because the monitored clock must stop while the sequencer keeps running. The bench gates its own system clock generator. It stops the clock once low and once high, and only starts it again after checking that the reset was asserted while the clock was still stopped. A sweep then covers every combination of pin, comparator low and clock stop with both source enables. This exercises the priority among causes that arrive together, as well as the case where a stopped clock or a low comparator is ignored.

// File: rtl/rst_hub.sv
module rst_hub #(
  parameter int MISS_CYC = 10000,
  parameter int HOLD     = 16,
  parameter int TICK_DIV = 12,
  parameter int HB_BIT   = 2
) (
  input  logic       clk,
  input  logic       ref_clk,
  input  logic       por_n,
  input  logic       pin_n,
  input  logic       cmp_out,
  input  logic       wdt_expire,
  input  logic       sup_ok,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       sys_rst,
  output logic [7:0] rd_data,
  output logic       wdt_en,
  output logic       wdt_tick
);
  localparam int MW = $clog2(MISS_CYC + 1);
  localparam int HW = $clog2(HOLD + 1);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  // system clock side
  logic [HB_BIT:0] hb_div;
  logic          mcd_en, cmp_en, sup_tg, wdt_tg;
  logic [TW-1:0] tick_cnt;
  logic          unused_bits;
  wire           wr_ok = wr_en & ~sys_rst;

  assign unused_bits = ^{wr_data[7:6], wr_data[4], wr_data[0]};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) hb_div <= '0;
    else        hb_div <= hb_div + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      mcd_en   <= 1'b0;
      cmp_en   <= 1'b0;
      wdt_en   <= 1'b1;
      sup_tg   <= 1'b0;
      wdt_tg   <= 1'b0;
      tick_cnt <= '0;
    end else begin
      if (wr_ok) begin
        mcd_en <= wr_data[2];
        cmp_en <= wr_data[5];
      end
      if (sys_rst)    wdt_en <= 1'b1;
      else if (wr_ok) wdt_en <= wr_data[3];
      if (wr_ok && wr_data[1] && sup_ok) sup_tg <= ~sup_tg;
      if (wdt_expire && wdt_en && !sys_rst) wdt_tg <= ~wdt_tg;
      if (sys_rst || !wdt_en || tick_cnt == TW'(TICK_DIV - 1)) tick_cnt <= '0;
      else tick_cnt <= tick_cnt + 1'b1;
    end

  assign wdt_tick = wdt_en & ~sys_rst & (tick_cnt == TW'(TICK_DIV - 1));

  // reference clock side
  logic [2:0]    hb_s, sup_s, wdt_s;
  logic [1:0]    pin_s, cmp_s, mcd_en_s, cmp_en_s;
  logic [MW-1:0] idle_cnt;
  logic [HW-1:0] hold;
  logic [4:0]    req, pick, flags;
  logic          rst_ref;

  always_ff @(posedge ref_clk or negedge por_n)
    if (!por_n) begin
      hb_s     <= '0;
      sup_s    <= '0;
      wdt_s    <= '0;
      pin_s    <= 2'b11;
      cmp_s    <= 2'b11;
      mcd_en_s <= '0;
      cmp_en_s <= '0;
    end else begin
      hb_s     <= {hb_s[1:0], hb_div[HB_BIT]};
      sup_s    <= {sup_s[1:0], sup_tg};
      wdt_s    <= {wdt_s[1:0], wdt_tg};
      pin_s    <= {pin_s[0], pin_n};
      cmp_s    <= {cmp_s[0], cmp_out};
      mcd_en_s <= {mcd_en_s[0], mcd_en};
      cmp_en_s <= {cmp_en_s[0], cmp_en};
    end

  always_ff @(posedge ref_clk or negedge por_n)
    if (!por_n)                 idle_cnt <= '0;
    else if (hb_s[2] != hb_s[1]) idle_cnt <= '0;
    else if (idle_cnt != MW'(MISS_CYC)) idle_cnt <= idle_cnt + 1'b1;

  assign req = { cmp_en_s[1] & ~cmp_s[1],
                 wdt_s[2] ^ wdt_s[1],
                 mcd_en_s[1] & (idle_cnt == MW'(MISS_CYC)),
                 sup_s[2] ^ sup_s[1],
                 ~pin_s[1] };
  assign pick = req & (~req + 5'd1);

  always_ff @(posedge ref_clk or negedge por_n)
    if (!por_n) begin
      hold    <= HW'(HOLD);
      rst_ref <= 1'b1;
      flags   <= '0;
    end else if (|req) begin
      hold    <= HW'(HOLD);
      rst_ref <= 1'b1;
      if (!rst_ref) flags <= pick;
    end else if (hold != '0) begin
      hold <= hold - 1'b1;
    end else begin
      rst_ref <= 1'b0;
    end

  assign rd_data = {2'b00, flags[4], 1'b0, flags[3:0]};

  // release synchronized to the system clock, assertion immediate
  logic [1:0] rel_s;
  always_ff @(posedge clk or posedge rst_ref)
    if (rst_ref) rel_s <= 2'b11;
    else         rel_s <= {rel_s[0], 1'b0};

  assign sys_rst = rel_s[1];
endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk #(
  parameter int HOLD = 16
) (
  input logic       clk,
  input logic       ref_clk,
  input logic       por_n,
  input logic       pin_n,
  input logic       sys_rst,
  input logic       rst_ref,
  input logic [7:0] rd_data,
  input logic       wdt_en,
  input logic       wdt_tick
);
  logic [7:0]  age;
  logic [15:0] run;

  always_ff @(posedge ref_clk or negedge por_n)
    if (!por_n) begin
      age <= '0;
      run <= '0;
    end else begin
      if (age != 8'hff) age <= age + 1'b1;
      if (!rst_ref)              run <= '0;
      else if (run != 16'hffff)  run <= run + 1'b1;
    end

  p_pin_reset_r1: assert property (@(posedge ref_clk) disable iff (!por_n)
    (age >= 8'd3 && $past(!pin_n, 3)) |-> sys_rst);

  p_min_hold_r7: assert property (@(posedge ref_clk) disable iff (!por_n)
    $fell(rst_ref) |-> (run >= 16'(HOLD)));

  p_cause_onehot_r6: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(rd_data) && ((rd_data & 8'hd0) == 8'h00));

  p_cause_stable_r6: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst |-> $stable(rd_data));

  p_wdt_on_r9: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> wdt_en);

  p_tick_pulse_r10: assert property (@(posedge clk) disable iff (!por_n)
    wdt_tick |=> !wdt_tick);

  p_tick_quiet_r10: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> !wdt_tick);
endmodule

bind rst_hub rst_hub_chk #(.HOLD(HOLD)) u_chk (
  .clk(clk), .ref_clk(ref_clk), .por_n(por_n), .pin_n(pin_n),
  .sys_rst(sys_rst), .rst_ref(rst_ref), .rd_data(rd_data),
  .wdt_en(wdt_en), .wdt_tick(wdt_tick)
);

// File: tb/rst_hub_test.sv
`timescale 1ns/1ps
module rst_hub_test;
  localparam int MISS = 20;
  localparam int HOLD = 16;

  logic clk = 1'b0, ref_clk = 1'b0, clk_run = 1'b1;
  logic por_n, pin_n, cmp_out, wdt_expire, sup_ok, wr_en;
  logic [7:0] wr_data, rd_data;
  logic sys_rst, wdt_en, wdt_tick;
  int checks = 0, errors = 0;

  rst_hub #(.MISS_CYC(MISS), .HOLD(HOLD)) uut (
    .clk(clk), .ref_clk(ref_clk), .por_n(por_n), .pin_n(pin_n),
    .cmp_out(cmp_out), .wdt_expire(wdt_expire), .sup_ok(sup_ok),
    .wr_en(wr_en), .wr_data(wr_data), .sys_rst(sys_rst),
    .rd_data(rd_data), .wdt_en(wdt_en), .wdt_tick(wdt_tick));

  initial forever begin #2.5; if (clk_run) clk = ~clk; end
  initial begin #3.1; forever begin ref_clk = ~ref_clk; #5; end end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); #1; wr_en = 1'b1; wr_data = d;
    @(negedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic wait_rel();
    for (int i = 0; i < 4000; i++) begin
      if (!sys_rst) break;
      #1;
    end
    #100;
  endtask

  task automatic wdt_pulse();
    @(negedge clk); #1; wdt_expire = 1'b1;
    @(negedge clk); #1; wdt_expire = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog (R1..): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    logic [7:0] exp_f;
    logic exp_r;
    real t0, t1;
    int n;
    por_n = 0; pin_n = 1; cmp_out = 1; wdt_expire = 0; sup_ok = 0;
    wr_en = 0; wr_data = 0;

    // R8 power-on
    #100; check("R8 sys_rst during por", sys_rst, 1);
    #1 por_n = 1;
    wait_rel();
    check("R8 released", sys_rst, 0);
    check("R8 status zero", rd_data, 8'h00);
    check("R8 wdt_en", wdt_en, 1);
    @(negedge clk); #1; cmp_out = 0; #400;
    check("R8 comparator disabled", sys_rst, 0);
    cmp_out = 1; #100;
    @(negedge clk); #1; clk_run = 0; #400;
    check("R8 clock loss disabled", sys_rst, 0);
    clk_run = 1; #100;

    // R1 / R7 pin reset and release timing
    @(negedge clk); #1; pin_n = 0; #50;
    check("R1 pin asserts", sys_rst, 1);
    #200; pin_n = 1; t0 = $realtime; #0.2;
    n = 0;
    while (sys_rst && n < 4000) begin #0.5; n++; end
    t1 = $realtime;
    check("R7 release on clk high", clk, 1);
    check("R7 hold length", (t1 - t0) >= HOLD * 10.0, 1);
    check("R1 status pin", rd_data, 8'h01);
    #100;

    // R6 sweep: pin, comparator low, clock stop x both enables
    prev = 8'h01;
    for (int i = 0; i < 32; i++) begin
      logic p, c, s, ce, me;
      {me, ce, s, c, p} = 5'(i);
      wr({2'b00, ce, 1'b0, 1'b1, me, 2'b00});
      #60;
      @(negedge clk); #1;
      pin_n = ~p; cmp_out = ~c; if (s) clk_run = 0;
      #400;
      exp_r = p | (c & ce) | (s & me);
      check($sformatf("R6 sweep %0d reset (R1 R2 R3)", i), sys_rst, exp_r);
      pin_n = 1; cmp_out = 1; clk_run = 1;
      wait_rel();
      exp_f = p ? 8'h01 : (c & ce) ? 8'h20 : (s & me) ? 8'h04 : prev;
      check($sformatf("R6 sweep %0d cause", i), rd_data, exp_f);
      prev = exp_f;
    end

    // R2 clock stuck high
    wr(8'h0c); #60;
    @(posedge clk); #1; clk_run = 0; #400;
    check("R2 stuck high resets", sys_rst, 1);
    clk_run = 1; wait_rel();
    check("R2 status clock loss", rd_data, 8'h04);
    wr(8'h08); #60;

    // R5 supply force
    sup_ok = 1; wr(8'h0a); #100;
    check("R5 forced reset", sys_rst, 1);
    wait_rel();
    check("R5 status supply", rd_data, 8'h02);
    sup_ok = 0; wr(8'h0a); #300;
    check("R5 ignored reset", sys_rst, 0);
    check("R5 ignored status", rd_data, 8'h02);

    // R4 / R9 watchdog
    check("R9 wdt_en set", wdt_en, 1);
    wdt_pulse(); #100;
    check("R4 watchdog reset", sys_rst, 1);
    wait_rel();
    check("R4 status watchdog", rd_data, 8'h08);
    wr(8'h00); #10;
    check("R9 wdt_en cleared", wdt_en, 0);
    wdt_pulse(); #300;
    check("R4 ignored reset", sys_rst, 0);
    check("R4 ignored status", rd_data, 8'h08);

    // R10 tick
    n = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (wdt_tick) n++; end
    check("R10 no tick when disabled", n, 0);
    wr(8'h08);
    n = 0;
    while (!wdt_tick && n < 40) begin @(negedge clk); n++; end
    for (int k = 0; k < 3; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!wdt_tick && n < 40);
      check("R10 tick period", n, 12);
    end

    // R9 reset re-enables the watchdog
    wr(8'h00); #10;
    @(negedge clk); #1; pin_n = 0; #100; pin_n = 1;
    wait_rel();
    check("R9 wdt_en after reset", wdt_en, 1);
    check("R1 status after pin", rd_data, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule